// File: doc/BRIEF.md
# Modular Butterfly Arithmetic Element

This block is a pipelined arithmetic element for wide modular arithmetic. Each cycle it can accept one operation made of two operands `a` and `b`, a twiddle `w`, a modulus `q`, a precomputed reduction constant `mu` and a 3-bit opcode. A fixed number of cycles later it returns one or two results, each reduced below `q`, together with a valid flag. The datapath has exactly one modular multiplier, one modular adder and one modular subtractor. A number-theoretic-transform butterfly uses all three at once. Plain multiply, add, subtract and a multiply-accumulate reuse the same units.

Operands are handled as full words of `WIDTH` bits, with no splitting into limbs. `WIDTH` defaults to 64 and may be set as high as 256. The product is reduced by Barrett reduction followed by two conditional subtractions of `q`. The modulus must satisfy 2^(WIDTH-1) <= q < 2^WIDTH. The caller supplies mu = floor(2^(2·WIDTH) / q). All operands must already be below `q`. The accumulator for the multiply-accumulate is internal. It can be zeroed by a clear input and by reset.

Top module: `modbfly_pe`

## Requirements
- R1: Opcode 0 (butterfly) returns res0 = (a + w·b) mod q and res1 = (a − w·b) mod q.
- R2: Opcode 1 (multiply) returns res0 = (a·b) mod q. For every opcode other than 0, res1 is zero.
- R3: Opcode 2 (add) returns res0 = (a + b) mod q, subtracting q once when the raw sum is at least q.
- R4: Opcode 3 (subtract) returns res0 = (a − b) mod q, adding q once when the raw difference is negative.
- R5: Opcode 4 (multiply-accumulate) sets acc to (acc + a·b) mod q and returns the new acc on res0. The accumulator changes only through this opcode, the clear input or reset.
- R6: When clr_acc_i is high at a rising clock edge, acc becomes zero at that edge. This takes priority over a multiply-accumulate completing at the same edge, so the next multiply-accumulate starts from zero.
- R7: An operation accepted with valid_i high at an edge produces exactly one valid_o pulse 4 rising edges later. Back-to-back operations are accepted every cycle, and their results come out on consecutive cycles in issue order.
- R8: For a modulus in [2^(WIDTH-1), 2^WIDTH), every result is below q, including when mu reaches its largest value at q = 2^(WIDTH-1) + small.
- R9: While rst_ni is low, and after it is released, valid_o, res0_o and res1_o are zero and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Opcode: 0 butterfly, 1 multiply, 2 add, 3 subtract, 4 multiply-accumulate |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| w_i | input | WIDTH | Twiddle factor, used by the butterfly |
| q_i | input | WIDTH | Modulus |
| mu_i | input | WIDTH+2 | Reduction constant floor(2^(2·WIDTH)/q) |
| clr_acc_i | input | 1 | Zero the accumulator at this edge |
| valid_o | output | 1 | Results valid |
| res0_o | output | WIDTH | Sum-side result or single result |
| res1_o | output | WIDTH | Difference-side butterfly result, else zero |

## Verification
Some properties are checked on every cycle. Each valid result must be below its modulus, and the reduced product leaving the Barrett stage must also be below the modulus. The second result must be zero for every opcode other than the butterfly. The accumulator must hold unless a multiply-accumulate completes or a clear is applied, and a clear must leave it at zero.

Only the bench scenarios can show the arithmetic values themselves, the four-edge latency, ordering under back-to-back issue, and the clear winning a collision with a completing multiply-accumulate. The bench checks these against a wide-integer reference for two moduli, one of which sits near the bottom of the allowed range.

// File: rtl/modbfly_pkg.sv
package modbfly_pkg;
  typedef enum logic [2:0] {
    OP_BFLY = 3'd0,
    OP_MUL  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MAC  = 3'd4
  } op_e;
endpackage

// File: rtl/modbfly_mult.sv
module modbfly_mult #(
  parameter int W = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   x_i,
  input  logic [W-1:0]   y_i,
  output logic [2*W-1:0] prod_o
);
  localparam int PW = 2 * W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_o <= '0;
    else         prod_o <= PW'(x_i) * PW'(y_i);
  end
endmodule

// File: rtl/modbfly_barrett.sv
module modbfly_barrett #(
  parameter int W    = 64,
  parameter int NSUB = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [2*W-1:0] x_i,
  input  logic [W-1:0]   q_i,
  input  logic [W+1:0]   mu_i,
  output logic [W-1:0]   p_o
);
  localparam int RW = W + 2;       // residue width before final correction
  localparam int TW = W + 1;       // x >> (W-1)
  localparam int MW = TW + RW;     // t * mu

  // stage 1: quotient estimate
  logic [TW-1:0] t;
  logic [MW-1:0] tm;
  logic [RW-1:0] qhat_d;

  assign t      = TW'(x_i >> (W - 1));
  assign tm     = MW'(t) * MW'(mu_i);
  assign qhat_d = RW'(tm >> (W + 1));

  logic [RW-1:0] qhat_q, xlo_q;
  logic [W-1:0]  q1_q;
  logic          v1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qhat_q <= '0;
      xlo_q  <= '0;
      q1_q   <= '0;
      v1_q   <= 1'b0;
    end else begin
      qhat_q <= qhat_d;
      xlo_q  <= RW'(x_i);
      q1_q   <= q_i;
      v1_q   <= valid_i;
    end
  end

  // stage 2: residue and conditional corrections
  logic [RW-1:0] qext;
  logic [RW-1:0] corr [NSUB+1];

  assign qext    = RW'(q1_q);
  assign corr[0] = xlo_q - RW'(qhat_q * qext);

  for (genvar g = 0; g < NSUB; g++) begin : g_corr
    assign corr[g+1] = (corr[g] >= qext) ? corr[g] - qext : corr[g];
  end

  logic [W-1:0] q2_q;
  logic         v2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_o  <= '0;
      q2_q <= '0;
      v2_q <= 1'b0;
    end else begin
      p_o  <= W'(corr[NSUB]);
      q2_q <= q1_q;
      v2_q <= v1_q;
    end
  end

  assert_red_lt_q_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_q |-> (p_o < q2_q));
endmodule

// File: rtl/modbfly_addsub.sv
module modbfly_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] add_x_i,
  input  logic [W-1:0] sub_x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o
);
  logic [W:0] raw_sum, raw_diff;

  assign raw_sum  = {1'b0, add_x_i} + {1'b0, y_i};
  assign raw_diff = {1'b0, sub_x_i} - {1'b0, y_i};

  // single correction suffices for reduced inputs
  assign sum_o  = (raw_sum >= {1'b0, q_i}) ? W'(raw_sum - {1'b0, q_i}) : W'(raw_sum);
  assign diff_o = raw_diff[W] ? W'(raw_diff + {1'b0, q_i}) : W'(raw_diff);
endmodule

// File: rtl/modbfly_pe.sv
module modbfly_pe
  import modbfly_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] w_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH+1:0] mu_i,
  input  logic             clr_acc_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] res0_o,
  output logic [WIDTH-1:0] res1_o
);
  localparam int W        = WIDTH;
  localparam int MUL_LAT  = 1;
  localparam int RED_LAT  = 2;
  localparam int SB_DEPTH = MUL_LAT + RED_LAT;
  localparam int LAST     = SB_DEPTH - 1;

  op_e          op_in;
  logic [W-1:0] mul_x;

  assign op_in = op_e'(op_i);
  assign mul_x = (op_in == OP_BFLY) ? w_i : a_i;

  // shared modular multiplier: raw product then Barrett reduction
  logic [2*W-1:0] prod;
  logic [W+1:0]   mu_q;
  logic [W-1:0]   prod_mod;

  modbfly_mult #(.W(W)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (mul_x),
    .y_i    (b_i),
    .prod_o (prod)
  );

  // sideband travels alongside the multiplier pipeline
  logic         sb_v  [SB_DEPTH];
  op_e          sb_op [SB_DEPTH];
  logic [W-1:0] sb_a  [SB_DEPTH];
  logic [W-1:0] sb_b  [SB_DEPTH];
  logic [W-1:0] sb_q  [SB_DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mu_q <= '0;
      for (int i = 0; i < SB_DEPTH; i++) begin
        sb_v[i]  <= 1'b0;
        sb_op[i] <= OP_BFLY;
        sb_a[i]  <= '0;
        sb_b[i]  <= '0;
        sb_q[i]  <= '0;
      end
    end else begin
      mu_q     <= mu_i;
      sb_v[0]  <= valid_i;
      sb_op[0] <= op_in;
      sb_a[0]  <= a_i;
      sb_b[0]  <= b_i;
      sb_q[0]  <= q_i;
      for (int i = 1; i < SB_DEPTH; i++) begin
        sb_v[i]  <= sb_v[i-1];
        sb_op[i] <= sb_op[i-1];
        sb_a[i]  <= sb_a[i-1];
        sb_b[i]  <= sb_b[i-1];
        sb_q[i]  <= sb_q[i-1];
      end
    end
  end

  modbfly_barrett #(.W(W), .NSUB(2)) u_red (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sb_v[0]),
    .x_i     (prod),
    .q_i     (sb_q[0]),
    .mu_i    (mu_q),
    .p_o     (prod_mod)
  );

  // shared modular adder and subtractor
  logic [W-1:0] acc_q;
  logic [W-1:0] add_x, y_sel, sum, diff;
  op_e          op_l;

  assign op_l = sb_op[LAST];

  always_comb begin
    unique case (op_l)
      OP_BFLY, OP_ADD: add_x = sb_a[LAST];
      OP_MAC:          add_x = acc_q;
      default:         add_x = '0;
    endcase
    y_sel = (op_l == OP_ADD || op_l == OP_SUB) ? sb_b[LAST] : prod_mod;
  end

  modbfly_addsub #(.W(W)) u_addsub (
    .add_x_i (add_x),
    .sub_x_i (sb_a[LAST]),
    .y_i     (y_sel),
    .q_i     (sb_q[LAST]),
    .sum_o   (sum),
    .diff_o  (diff)
  );

  logic [W-1:0] r0_d, r1_d;

  always_comb begin
    r0_d = '0;
    r1_d = '0;
    unique case (op_l)
      OP_BFLY: begin r0_d = sum; r1_d = diff; end
      OP_MUL, OP_ADD, OP_MAC: r0_d = sum;
      OP_SUB:  r0_d = diff;
      default: ;
    endcase
  end

  logic mac_fire;
  assign mac_fire = sb_v[LAST] && (op_l == OP_MAC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (clr_acc_i) acc_q <= '0;
    else if (mac_fire)  acc_q <= sum;
  end

  logic [W-1:0] q_o;
  op_e          op_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res0_o  <= '0;
      res1_o  <= '0;
      q_o     <= '0;
      op_o    <= OP_BFLY;
    end else begin
      valid_o <= sb_v[LAST];
      res0_o  <= r0_d;
      res1_o  <= r1_d;
      q_o     <= sb_q[LAST];
      op_o    <= op_l;
    end
  end

  assert_res_lt_q_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (res0_o < q_o && res1_o < q_o));

  assert_res1_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_o != OP_BFLY) |-> (res1_o == '0));

  assert_acc_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_acc_i && !mac_fire) |=> $stable(acc_q));

  assert_clr_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_acc_i |=> (acc_q == '0));
endmodule

// File: tb/modbfly_pe_tb.sv
module modbfly_pe_tb_top;
  localparam int W          = 64;
  localparam int CLK_PERIOD = 10;
  localparam logic [W-1:0] Q1 = 64'hFFFF_FFFF_0000_0001;
  localparam logic [W-1:0] Q2 = 64'h8000_0000_0000_001D;

  typedef struct packed {
    logic [2:0]   op;
    logic [W-1:0] a, b, w, e0, e1;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 64'd10,  64'd3,        64'd5,    64'd25,        Q1 - 64'd5},
    '{3'd0, Q1 - 1,  64'd1,        64'd1,    64'd0,         Q1 - 64'd2},
    '{3'd0, 64'd0,   Q1 - 1,       Q1 - 1,   64'd1,         Q1 - 64'd1},
    '{3'd1, 64'd7,   64'd6,        64'd0,    64'd42,        64'd0},
    '{3'd1, Q1 - 1,  Q1 - 1,       64'd0,    64'd1,         64'd0},
    '{3'd1, 64'h1_0000_0000, 64'h1_0000_0000, 64'd0, 64'hFFFF_FFFF, 64'd0},
    '{3'd2, Q1 - 1,  64'd2,        64'd0,    64'd1,         64'd0},
    '{3'd2, 64'd3,   64'd4,        64'd0,    64'd7,         64'd0},
    '{3'd2, Q1 - 1,  64'd1,        64'd0,    64'd0,         64'd0},
    '{3'd3, 64'd2,   64'd5,        64'd0,    Q1 - 64'd3,    64'd0},
    '{3'd3, 64'd9,   64'd4,        64'd0,    64'd5,         64'd0},
    '{3'd3, 64'd4,   64'd4,        64'd0,    64'd0,         64'd0}
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [2:0]     op_i = '0;
  logic [W-1:0]   a_i = '0, b_i = '0, w_i = '0, q_i = Q1;
  logic [W+1:0]   mu_i = '0;
  logic           clr_acc_i = 1'b0;
  logic           valid_o;
  logic [W-1:0]   res0_o, res1_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  modbfly_pe #(.WIDTH(W)) dut_i (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .w_i, .q_i, .mu_i,
    .clr_acc_i, .valid_o, .res0_o, .res1_o
  );

  function automatic logic [W+1:0] mu_of(logic [W-1:0] q);
    logic [2*W+1:0] n;
    n = (2*W+2)'(1) << (2 * W);
    return (W+2)'(n / (2*W+2)'(q));
  endfunction

  function automatic logic [W-1:0] mulmod(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] q);
    logic [2*W-1:0] p;
    p = (2*W)'(x) * (2*W)'(y);
    return W'(p % (2*W)'(q));
  endfunction

  function automatic logic [W-1:0] addmod(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] q);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return (s >= {1'b0, q}) ? W'(s - {1'b0, q}) : W'(s);
  endfunction

  function automatic logic [W-1:0] submod(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] q);
    return (x >= y) ? x - y : W'({1'b0, x} + {1'b0, q} - {1'b0, y});
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic set_mod(logic [W-1:0] q);
    q_i  = q;
    mu_i = mu_of(q);
  endtask

  // one isolated operation, measuring latency in edges
  task automatic single(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] w,
                        output logic [W-1:0] r0, output logic [W-1:0] r1, output int lat);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; w_i = w;
    lat = 0;
    r0 = '0; r1 = '0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
      lat++;
      if (valid_o) begin
        r0 = res0_o; r1 = res1_o;
        break;
      end
    end
  endtask

  // back-to-back issue of n operations, pseudo-random reduced operands
  task automatic stream(logic [W-1:0] q, logic [2:0] op, int n, logic [W-1:0] seed, string tag);
    logic [W-1:0] sa [16], sb [16], sw [16], e0 [16], e1 [16];
    logic [W-1:0] st, acc, wb;
    st  = seed;
    acc = '0;
    for (int i = 0; i < n; i++) begin
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407; sa[i] = st % q;
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407; sb[i] = st % q;
      st = st * 64'd6364136223846793005 + 64'd1442695040888963407; sw[i] = st % q;
      if (i == 0) begin sa[i] = q - 1; sb[i] = q - 1; sw[i] = q - 1; end
      e1[i] = '0;
      case (op)
        3'd0: begin
          wb = mulmod(sw[i], sb[i], q);
          e0[i] = addmod(sa[i], wb, q);
          e1[i] = submod(sa[i], wb, q);
        end
        3'd1: e0[i] = mulmod(sa[i], sb[i], q);
        default: begin
          acc = addmod(acc, mulmod(sa[i], sb[i], q), q);
          e0[i] = acc;
        end
      endcase
    end
    for (int c = 0; c < n + 5; c++) begin
      @(negedge clk_i);
      if (c >= 4 && c < n + 4) begin
        chk({tag, " R7 valid"}, W'(valid_o), W'(1));
        chk({tag, " res0"}, res0_o, e0[c-4]);
        chk({tag, " res1"}, res1_o, e1[c-4]);
      end
      if (c == n + 4) chk("R7 no extra valid", W'(valid_o), W'(0));
      if (c < n) begin
        valid_i = 1'b1; op_i = op; a_i = sa[c]; b_i = sb[c]; w_i = sw[c];
      end else begin
        valid_i = 1'b0;
      end
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clr_acc_i = 1'b1;
    @(negedge clk_i); clr_acc_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] r0, r1;
    int lat;
    string tg;

    set_mod(Q1);
    repeat (3) @(negedge clk_i);
    // R9: outputs quiet during reset
    chk("R9 valid in reset", W'(valid_o), W'(0));
    chk("R9 res0 in reset", res0_o, '0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R9 valid after reset", W'(valid_o), W'(0));
    chk("R9 res1 after reset", res1_o, '0);

    // vector table: R1 butterfly, R2 multiply, R3 add, R4 subtract
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        3'd0: tg = "R1";
        3'd1: tg = "R2";
        3'd2: tg = "R3";
        default: tg = "R4";
      endcase
      single(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].w, r0, r1, lat);
      chk({tg, " res0"}, r0, VECS[i].e0);
      chk({tg, " res1"}, r1, VECS[i].e1);
      chk("R7 latency", W'(lat), W'(4));
    end

    // R1 R7: full-throughput butterflies, both moduli (R8 low-end modulus)
    stream(Q1, 3'd0, 12, 64'h1234_5678_9ABC_DEF0, "R1 stream q1");
    set_mod(Q2);
    stream(Q2, 3'd0, 12, 64'h0F0E_0D0C_0B0A_0908, "R8 stream q2");
    stream(Q2, 3'd1, 10, 64'hDEAD_BEEF_0000_1111, "R2 stream q2");

    // R5: back-to-back multiply-accumulate from a cleared accumulator
    pulse_clear();
    stream(Q2, 3'd4, 8, 64'h5555_AAAA_3333_CCCC, "R5 mac q2");
    set_mod(Q1);
    pulse_clear();
    stream(Q1, 3'd4, 6, 64'h0123_4567_89AB_CDEF, "R5 mac q1");

    // R6: clear collides with a completing multiply-accumulate
    pulse_clear();
    single(3'd4, 64'd5, 64'd6, 64'd0, r0, r1, lat);
    chk("R6 setup mac", r0, 64'd30);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = 3'd4; a_i = 64'd100; b_i = 64'd100;
    @(negedge clk_i); valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i); clr_acc_i = 1'b1;   // high at the completing edge
    @(negedge clk_i); clr_acc_i = 1'b0;
    single(3'd4, 64'd3, 64'd4, 64'd0, r0, r1, lat);
    chk("R6 clear wins", r0, 64'd12);

    // R9: reset clears a nonzero accumulator
    single(3'd4, 64'd7, 64'd7, 64'd0, r0, r1, lat);
    chk("R5 accumulate", r0, 64'd61);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R9 valid in mid reset", W'(valid_o), W'(0));
    rst_ni = 1'b1;
    single(3'd4, 64'd3, 64'd4, 64'd0, r0, r1, lat);
    chk("R9 acc after reset", r0, 64'd12);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule